// File: doc/BRIEF.md
# Predicated Floating-Point Minimum Reduction Unit

This unit takes a vector of `LANES` floating-point elements and a predicate bit for each lane, and returns the smallest active element as one scalar. Each lane sits in its own 64-bit slot of the input bus: lane `i` occupies bits `[64*i+63 : 64*i]`. The element format is chosen per operation by a two-bit format code, and applies to every lane of that operation: half precision (16 bits), single precision (32 bits) or double precision (64 bits). The element is always held in the low bits of its slot.

A lane whose predicate bit is clear takes part as +Infinity, so it can never win. The active lanes are combined in a fixed binary tree: adjacent pairs first, then pairs of those results, and so on until one value is left. Each tree level ends in a register, so an operation accepted with `in_valid` comes out with `out_valid` a fixed number of cycles later. A new operation may enter on every cycle.

Comparison follows IEEE 754 minimum rules, including signed zeros, infinities and NaNs. Any NaN among the active lanes gives a quiet NaN result. If any active lane holds a signalling NaN, an invalid-operation pulse is raised together with the result. The scalar is zero-extended into a wider destination word. The unit produces no condition flags.

Top module: `fp_min_reduce`

## Requirements
- R1: A lane whose predicate bit is 0 acts as +Infinity, whatever its slot holds; a masked -Infinity or NaN does not change the result.
- R2: With no predicate bit set, the result is +Infinity of the selected format: 0x7C00 for half, 0x7F800000 for single, 0x7FF0000000000000 for double.
- R3: Format code 0 selects half (slot bits 15:0), 1 selects single (slot bits 31:0) and 2 selects double (all 64 bits); slot bits above the element width have no effect on the result.
- R4: The result sits in the low element-width bits of `out_result`, and every bit above the element width is 0.
- R5: Non-NaN ordering is by sign and magnitude: any negative value is below any positive value, a larger magnitude is smaller among negatives, -Infinity is the lowest and -0.0 is below +0.0.
- R6: If any active lane is a NaN, the result is the lowest-indexed active NaN lane with its quiet bit (mantissa MSB: bit 9 half, bit 22 single, bit 51 double) set and its payload kept.
- R7: `out_invalid` is 1 in the cycle `out_valid` is 1 exactly when an active lane held a signalling NaN (quiet bit 0, mantissa not 0); it is 0 otherwise.
- R8: `out_valid` rises exactly log2(`LANES`) cycles after `in_valid` is sampled, and back-to-back operations come out on back-to-back cycles in order.
- R9: A synchronous active-high reset drops `out_valid` and `out_invalid` at the next edge and discards operations in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs |
| in_fmt | input | 2 | Format code: 0 half, 1 single, 2 double |
| in_lanes | input | 64*LANES | Lane slots, lane i at bits 64*i+63:64*i |
| in_pred | input | LANES | Predicate bit per lane, 1 = active |
| out_valid | output | 1 | Result present |
| out_result | output | DST_W | Minimum, zero-extended |
| out_invalid | output | 1 | Signalling NaN seen among active lanes |

## Verification
The hardest case to reach from the ports is a vector with several NaNs, where the lowest-indexed one is in a lane that is not the first. The result then shows whether the tree prefers its left operand at every level, and whether a quiet NaN from a masked lane is kept out. Uniform random bit patterns almost never produce NaNs, signed zeros or infinities. The stimulus therefore draws each element from weighted classes (zeros of either sign, infinities, quiet and signalling NaNs, and random patterns) and fills the unused upper slot bits with noise. Directed vectors add masked -Infinity, mixed zeros, two NaNs in separate subtrees, and a reset that arrives while operations are still in the pipeline.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

    localparam int SLOT_W = 64;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2
    } fmt_e;

    typedef struct packed {
        logic [SLOT_W-1:0] val;
        logic              sig;
    } node_t;

    function automatic logic [SLOT_W-1:0] elem_mask(fmt_e f);
        case (f)
            FMT_HALF:   return 64'h0000_0000_0000_FFFF;
            FMT_SINGLE: return 64'h0000_0000_FFFF_FFFF;
            default:    return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] sign_mask(fmt_e f);
        case (f)
            FMT_HALF:   return 64'h0000_0000_0000_8000;
            FMT_SINGLE: return 64'h0000_0000_8000_0000;
            default:    return 64'h8000_0000_0000_0000;
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] expo_mask(fmt_e f);
        case (f)
            FMT_HALF:   return 64'h0000_0000_0000_7C00;
            FMT_SINGLE: return 64'h0000_0000_7F80_0000;
            default:    return 64'h7FF0_0000_0000_0000;
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] mant_mask(fmt_e f);
        case (f)
            FMT_HALF:   return 64'h0000_0000_0000_03FF;
            FMT_SINGLE: return 64'h0000_0000_007F_FFFF;
            default:    return 64'h000F_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] quiet_bit(fmt_e f);
        case (f)
            FMT_HALF:   return 64'h0000_0000_0000_0200;
            FMT_SINGLE: return 64'h0000_0000_0040_0000;
            default:    return 64'h0008_0000_0000_0000;
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] pos_inf(fmt_e f);
        return expo_mask(f);
    endfunction

    function automatic logic is_nan(logic [SLOT_W-1:0] v, fmt_e f);
        return ((v & expo_mask(f)) == expo_mask(f)) && ((v & mant_mask(f)) != '0);
    endfunction

    function automatic logic is_snan(logic [SLOT_W-1:0] v, fmt_e f);
        return is_nan(v, f) && ((v & quiet_bit(f)) == '0);
    endfunction

    // true when a is strictly below b (both non-NaN)
    function automatic logic fp_less(logic [SLOT_W-1:0] a, logic [SLOT_W-1:0] b, fmt_e f);
        logic              sa;
        logic              sb;
        logic [SLOT_W-1:0] ma;
        logic [SLOT_W-1:0] mb;
        sa = |(a & sign_mask(f));
        sb = |(b & sign_mask(f));
        ma = a & (expo_mask(f) | mant_mask(f));
        mb = b & (expo_mask(f) | mant_mask(f));
        if (sa != sb) return sa;
        if (!sa)      return ma < mb;
        return ma > mb;
    endfunction

endpackage

// File: rtl/fmr_lane_prep.sv
module fmr_lane_prep
    import fmr_pkg::*;
(
    input  fmt_e              fmt,
    input  logic              active,
    input  logic [SLOT_W-1:0] raw,
    output node_t             leaf
);
    logic [SLOT_W-1:0] elem;
    logic              snan;

    always_comb begin
        elem = raw & elem_mask(fmt);
        snan = is_snan(elem, fmt);
        if (!active) begin
            leaf.val = pos_inf(fmt);
            leaf.sig = 1'b0;
        end else begin
            leaf.val = is_nan(elem, fmt) ? (elem | quiet_bit(fmt)) : elem;
            leaf.sig = snan;
        end
    end
endmodule

// File: rtl/fmr_min2.sv
module fmr_min2
    import fmr_pkg::*;
(
    input  fmt_e  fmt,
    input  node_t a,
    input  node_t b,
    output node_t y
);
    logic a_nan;
    logic b_nan;

    always_comb begin
        a_nan = is_nan(a.val, fmt);
        b_nan = is_nan(b.val, fmt);
        if (a_nan)
            y.val = a.val;
        else if (b_nan)
            y.val = b.val;
        else if (fp_less(b.val, a.val, fmt))
            y.val = b.val;
        else
            y.val = a.val;
        y.sig = a.sig | b.sig;
    end
endmodule

// File: rtl/fmr_stage.sv
module fmr_stage
    import fmr_pkg::*;
#(
    parameter int N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  fmt_e              in_fmt,
    input  node_t [N-1:0]     d,
    output logic              out_valid,
    output fmt_e              out_fmt,
    output node_t [N/2-1:0]   q
);
    localparam int M = N / 2;

    node_t [M-1:0] y;

    for (genvar k = 0; k < M; k++) begin : g_pair
        fmr_min2 u_min2 (
            .fmt (in_fmt),
            .a   (d[2*k]),
            .b   (d[2*k+1]),
            .y   (y[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
        out_fmt <= in_fmt;
        q       <= y;
    end
endmodule

// File: rtl/fp_min_reduce.sv
module fp_min_reduce
    import fmr_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DST_W = 128
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [1:0]              in_fmt,
    input  logic [SLOT_W*LANES-1:0] in_lanes,
    input  logic [LANES-1:0]        in_pred,
    output logic                    out_valid,
    output logic [DST_W-1:0]        out_result,
    output logic                    out_invalid
);
    localparam int LEVELS = $clog2(LANES);

    fmt_e                fmt_in;
    node_t [LANES-1:0]   leaf;

    assign fmt_in = fmt_e'(in_fmt);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        fmr_lane_prep u_prep (
            .fmt    (fmt_in),
            .active (in_pred[i]),
            .raw    (in_lanes[SLOT_W*i +: SLOT_W]),
            .leaf   (leaf[i])
        );
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int NI = LANES >> l;
        node_t [NI/2-1:0] q;
        logic             v;
        fmt_e             f;
        if (l == 0) begin : g_first
            fmr_stage #(.N(NI)) u_stage (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (in_valid),
                .in_fmt    (fmt_in),
                .d         (leaf),
                .out_valid (v),
                .out_fmt   (f),
                .q         (q)
            );
        end else begin : g_next
            fmr_stage #(.N(NI)) u_stage (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (g_lvl[l-1].v),
                .in_fmt    (g_lvl[l-1].f),
                .d         (g_lvl[l-1].q),
                .out_valid (v),
                .out_fmt   (f),
                .q         (q)
            );
        end
    end

    node_t root;
    fmt_e  root_fmt;

    assign root      = g_lvl[LEVELS-1].q[0];
    assign root_fmt  = g_lvl[LEVELS-1].f;
    assign out_valid = g_lvl[LEVELS-1].v;

    always_comb begin
        out_result = '0;
        out_result[SLOT_W-1:0] = root.val & elem_mask(root_fmt);
        out_invalid = out_valid & root.sig;
    end
endmodule

// File: rtl/fmr_checker.sv
module fmr_checker
    import fmr_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DST_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       in_fmt,
    input logic [LANES-1:0] in_pred,
    input logic             out_valid,
    input logic [DST_W-1:0] out_result,
    input logic             out_invalid
);
    localparam int LEVELS = $clog2(LANES);

    logic       vp [LEVELS];
    logic       np [LEVELS];
    logic [1:0] fp [LEVELS];

    always_ff @(posedge clk) begin
        for (int i = LEVELS - 1; i > 0; i--) begin
            vp[i] <= rst ? 1'b0 : vp[i-1];
            np[i] <= np[i-1];
            fp[i] <= fp[i-1];
        end
        vp[0] <= rst ? 1'b0 : in_valid;
        np[0] <= (in_pred == '0);
        fp[0] <= in_fmt;
    end

    fmt_e            dfmt;
    logic [DST_W-1:0] wmask;
    logic [DST_W-1:0] inf_w;

    always_comb begin
        dfmt  = fmt_e'(fp[LEVELS-1]);
        wmask = '0;
        wmask[SLOT_W-1:0] = elem_mask(dfmt);
        inf_w = '0;
        inf_w[SLOT_W-1:0] = pos_inf(dfmt);
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == vp[LEVELS-1]); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_invalid)); // R9

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_result & ~wmask) == '0)); // R4

    AST_EMPTY_INF: assert property (@(posedge clk) disable iff (rst)
        (out_valid && np[LEVELS-1]) |-> (out_result == inf_w)); // R2

    AST_INVALID_QUAL: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> (out_valid && is_nan(out_result[SLOT_W-1:0], dfmt))); // R7

    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (out_valid && is_nan(out_result[SLOT_W-1:0], dfmt))
            |-> ((out_result[SLOT_W-1:0] & quiet_bit(dfmt)) != '0)); // R6
endmodule

bind fp_min_reduce fmr_checker #(.LANES(LANES), .DST_W(DST_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_fmt      (in_fmt),
    .in_pred     (in_pred),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_invalid (out_invalid)
);

// File: tb/fp_min_reduce_tb_top.sv
module fp_min_reduce_tb_top;
    localparam int LANES  = 8;
    localparam int DST_W  = 128;
    localparam int LEVELS = $clog2(LANES);

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic [1:0]            in_fmt = 2'd0;
    logic [64*LANES-1:0]   in_lanes = '0;
    logic [LANES-1:0]      in_pred = '0;
    logic                  out_valid;
    logic [DST_W-1:0]      out_result;
    logic                  out_invalid;

    fp_min_reduce #(.LANES(LANES), .DST_W(DST_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_lanes(in_lanes), .in_pred(in_pred), .out_valid(out_valid),
        .out_result(out_result), .out_invalid(out_invalid)
    );

    always #10 clk = ~clk; // 50 MHz

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    typedef struct {
        logic [DST_W-1:0] res;
        logic             inv;
        int               due;
    } exp_t;

    exp_t  dq[$];
    string tq[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, logic [DST_W-1:0] act, logic [DST_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // format geometry, derived from widths
    function automatic int fw(int f);
        return (f == 0) ? 16 : (f == 1) ? 32 : 64;
    endfunction
    function automatic int ebits(int f);
        return (f == 0) ? 5 : (f == 1) ? 8 : 11;
    endfunction
    function automatic logic [63:0] wmask(int f);
        return (fw(f) == 64) ? {64{1'b1}} : ((64'd1 << fw(f)) - 64'd1);
    endfunction
    function automatic logic [63:0] mmask(int f);
        return (64'd1 << (fw(f) - 1 - ebits(f))) - 64'd1;
    endfunction
    function automatic logic [63:0] emask(int f);
        return (wmask(f) >> 1) & ~mmask(f);
    endfunction
    function automatic logic [63:0] qbit(int f);
        return 64'd1 << (fw(f) - 2 - ebits(f));
    endfunction
    function automatic logic [63:0] sbit(int f);
        return 64'd1 << (fw(f) - 1);
    endfunction

    function automatic logic [64:0] order_key(logic [63:0] e, int f);
        logic [63:0] mag;
        mag = e & (wmask(f) >> 1);
        if ((e & sbit(f)) != 0) return {1'b0, (wmask(f) >> 1) - mag};
        return {1'b1, mag};
    endfunction

    task automatic model(int f, logic [64*LANES-1:0] lanes, logic [LANES-1:0] pred,
                         output logic [63:0] res, output logic inv);
        bit          got_nan = 0;
        logic [63:0] nan_v   = '0;
        res = emask(f);
        inv = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            logic [63:0] e;
            e = lanes[64*i +: 64] & wmask(f);
            if (pred[i]) begin
                if ((e & emask(f)) == emask(f) && (e & mmask(f)) != 0) begin
                    if ((e & qbit(f)) == 0) inv = 1'b1;
                    if (!got_nan) begin
                        got_nan = 1;
                        nan_v   = e | qbit(f);
                    end
                end else if (order_key(e, f) < order_key(res, f)) begin
                    res = e;
                end
            end
        end
        if (got_nan) res = nan_v;
    endtask

    task automatic send(int f, logic [64*LANES-1:0] lanes, logic [LANES-1:0] pred, string tag);
        exp_t        x;
        logic [63:0] r;
        logic        v;
        @(negedge clk);
        in_valid = 1'b1;
        in_fmt   = 2'(f);
        in_lanes = lanes;
        in_pred  = pred;
        model(f, lanes, pred, r, v);
        x.res = DST_W'(r);
        x.inv = v;
        x.due = cyc + LEVELS;
        dq.push_back(x);
        tq.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_lanes = {LANES{$urandom, $urandom}};
        end
    endtask

    function automatic logic [63:0] gen_elem(int f);
        logic [63:0] junk;
        logic [63:0] v;
        logic [63:0] s;
        junk = {$urandom, $urandom};
        s    = ($urandom_range(0, 1) == 1) ? sbit(f) : 64'd0;
        case ($urandom_range(0, 9))
            0: v = s;
            1: v = s | emask(f);
            2: v = s | emask(f) | qbit(f) | (64'($urandom) & mmask(f));
            3: v = s | emask(f) | 64'd1 | (64'($urandom) & mmask(f) & ~qbit(f));
            default: v = {$urandom, $urandom};
        endcase
        return (junk & ~wmask(f)) | (v & wmask(f));
    endfunction

    // output monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit exp_v;
            exp_v = (dq.size() > 0) && (dq[0].due == cyc);
            check(out_valid == exp_v, "R8", "out_valid timing", DST_W'(out_valid), DST_W'(exp_v));
            if (exp_v) begin
                exp_t  x;
                string t;
                x = dq.pop_front();
                t = tq.pop_front();
                check(out_result == x.res, t, "result", out_result, x.res);
                check(out_invalid == x.inv, "R7", "invalid", DST_W'(out_invalid), DST_W'(x.inv));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [64*LANES-1:0] v;
        void'($urandom(32'd4242));

        // R9: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid in reset", DST_W'(out_valid), '0);
        check(out_invalid == 1'b0, "R9", "out_invalid in reset", DST_W'(out_invalid), '0);
        rst = 1'b0;

        // R2: nothing active, each format; slots hold noise
        for (int f = 0; f < 3; f++) send(f, {LANES{$urandom, $urandom}}, '0, "R2");

        // R1: masked -Inf and masked NaN ignored, active lanes positive
        v = '0;
        for (int i = 0; i < LANES; i++) v[64*i +: 64] = 64'h3FF0_0000_0000_0000 + 64'(i);
        v[64*2 +: 64] = 64'hFFF0_0000_0000_0000;
        v[64*5 +: 64] = 64'h7FF8_0000_0000_0001;
        send(2, v, 8'b1101_1011, "R1");

        // R5: -0 against +0, half
        v = '0;
        for (int i = 0; i < LANES; i++) v[64*i +: 64] = 64'h0000_0000_0000_3C00;
        v[64*6 +: 64] = 64'h0000_0000_0000_8000;
        v[64*1 +: 64] = 64'h0000_0000_0000_0000;
        send(0, v, 8'b0100_0010, "R5");
        // R5: negatives, larger magnitude wins, single
        v[64*0 +: 64] = 64'h0000_0000_C000_0000;
        v[64*7 +: 64] = 64'h0000_0000_C100_0000;
        send(1, v, 8'b1000_0001, "R5");

        // R3: upper slot bits noisy, single
        v = {LANES{64'hDEAD_BEEF_4000_0000}};
        v[64*4 +: 64] = 64'h8000_0000_3F80_0000;
        send(1, v, '1, "R3");

        // R6, R7: quiet NaN at lane 6, signalling NaN at lane 3 -> lane 3 quieted
        v = {LANES{64'h0000_0000_0000_4000}};
        v[64*6 +: 64] = 64'h0000_0000_0000_7E11;
        v[64*3 +: 64] = 64'h0000_0000_0000_7C05;
        send(0, v, '1, "R6");
        // R6: quiet NaN only, no invalid
        v[64*3 +: 64] = 64'h0000_0000_0000_4000;
        send(0, v, '1, "R6");

        // R4: double with sign set, upper destination bits zero
        send(2, {LANES{64'hC000_0000_0000_0000}}, '1, "R4");
        idle(LEVELS + 2);

        // R9: reset with operations in flight
        send(1, {LANES{64'h0000_0000_3F80_0000}}, '1, "R9");
        send(1, {LANES{64'h0000_0000_3F80_0000}}, '1, "R9");
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        dq.delete();
        tq.delete();
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid after reset", DST_W'(out_valid), '0);
        rst = 1'b0;
        idle(LEVELS + 2);

        // R5/R6/R7/R8: random mix, back-to-back
        for (int n = 0; n < 600; n++) begin
            int               f;
            logic [LANES-1:0] p;
            f = $urandom_range(0, 2);
            case ($urandom_range(0, 7))
                0:       p = '0;
                1:       p = '1;
                default: p = LANES'($urandom);
            endcase
            for (int i = 0; i < LANES; i++) v[64*i +: 64] = gen_elem(f);
            send(f, v, p, "R5");
            if ($urandom_range(0, 9) == 0) idle(1);
        end
        idle(LEVELS + 3);
        check(dq.size() == 0, "R8", "pending results", DST_W'(dq.size()), '0);

        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule